// File: doc/BRIEF.md
# Multi-Channel DAC Bus Loader

This block sits between an 8-bit processor bus and four double-buffered 12-bit converter channels. Each channel has a first rank of three 4-bit input latches and a second rank that feeds the converter. The processor writes each 12-bit code as two bytes to two neighbouring addresses. The loader turns each bus write into one-cycle active-low strobes toward the addressed channel. Those strobes are a write strobe, one enable for each nibble latch, and a second-rank load enable. It also places the byte on a shared 12-bit data lane.

The processor sets a layout input to pick one of two byte layouts. In the right-justified layout the first byte holds the low eight bits and the second byte holds the top four bits in its low nibble. In the left-justified layout the first byte holds the top eight bits and the second byte holds the bottom four bits in its high nibble. In both layouts the second byte completes the word. In direct mode, that same write also moves the channel's first rank into its second rank. In broadcast mode, the completing write only fills the first rank. One extra address then loads the second rank of every channel in the same cycle, so all outputs change together.

Top module: `dac_bus_loader`

## Requirements
- R1: While reset is asserted and after its release with no write, every ch_wr_n, ch_nib_n and ch_ldac_n bit is 1 and ch_data is 0.
- R2: A write (bus_cs_n=0 and bus_wr_n=0 at a rising edge) drives its strobes and data on the outputs for exactly the following clock cycle. A cycle with no write leaves every strobe at 1 and ch_data at 0 in the next cycle.
- R3: The block spans 2^(CH_BITS+2) addresses whose upper bits match BASE_ADDR. Offset 2k+p selects channel k and byte p, where p=0 is the first byte and p=1 is the completing byte.
- R4: With left_just=0, a p=0 write enables the middle and lower nibbles and puts the byte on ch_data[7:0]. A p=1 write enables the upper nibble and puts bus_data[3:0] on ch_data[11:8]. All other lanes are 0.
- R5: With left_just=1, a p=0 write enables the upper and middle nibbles and puts the byte on ch_data[11:4]. A p=1 write enables the lower nibble and puts bus_data[7:4] on ch_data[3:0]. All other lanes are 0.
- R6: With bcast_mode=0, a p=1 write also pulls that channel's ch_ldac_n low. A p=0 write never does.
- R7: With bcast_mode=1, no channel-select write asserts any ch_ldac_n bit.
- R8: A write to offset 2^(CH_BITS+1) pulls every ch_wr_n and ch_ldac_n bit low, enables no nibble and leaves ch_data at 0, in either mode.
- R9: Writes to offsets above the broadcast offset, or to addresses outside the block, assert nothing.
- R10: A channel-select write strobes only the addressed channel. Nibble bits for channel k sit at ch_nib_n[3k+2] (upper, code bits 11..8), [3k+1] (middle, bits 7..4) and [3k] (lower, bits 3..0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Processor address |
| bus_data | input | 8 | Processor write data |
| bus_cs_n | input | 1 | Active-low chip select |
| bus_wr_n | input | 1 | Active-low write strobe |
| left_just | input | 1 | 1 selects the left-justified byte layout |
| bcast_mode | input | 1 | 1 leaves the second-rank load to the broadcast address |
| ch_wr_n | output | 2^CH_BITS | Per-channel write strobe, active low |
| ch_nib_n | output | 3*2^CH_BITS | Per-channel nibble latch enables, active low |
| ch_ldac_n | output | 2^CH_BITS | Per-channel second-rank load enable, active low |
| ch_data | output | 12 | Data lanes shared by all channels |

## Verification
The bench builds the block at its defaults: ADDR_W=16, CH_BITS=2 (four channels, a 16-address block) and BASE_ADDR=16'h04C0. With these values a sweep over every offset in the block is small enough to run for both layouts, both update modes and several data patterns. That sweep covers every channel and byte position, the broadcast offset and every unused offset. Addresses just below and above the block, and writes gated off by chip select or write strobe, cover the cases that must assert nothing.

// File: rtl/dac_bus_loader.sv
module dac_bus_loader #(
  parameter int ADDR_W = 16,
  parameter int CH_BITS = 2,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h04C0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [7:0]               bus_data,
  input  logic                     bus_cs_n,
  input  logic                     bus_wr_n,
  input  logic                     left_just,
  input  logic                     bcast_mode,
  output logic [(1<<CH_BITS)-1:0]  ch_wr_n,
  output logic [3*(1<<CH_BITS)-1:0] ch_nib_n,
  output logic [(1<<CH_BITS)-1:0]  ch_ldac_n,
  output logic [11:0]              ch_data
);
  localparam int NUM_CH = 1 << CH_BITS;
  localparam int OFS_W  = CH_BITS + 2;
  localparam logic [OFS_W-1:0] BC_OFS = OFS_W'(2 * NUM_CH);

  logic [OFS_W-1:0] ofs;
  logic             wr_cyc, in_blk, hit_part, hit_bc, part;
  logic [CH_BITS-1:0] sel;
  logic [2:0]       nib_pat;
  logic [11:0]      data_d;
  logic [NUM_CH-1:0]   wr_d, ld_d;
  logic [3*NUM_CH-1:0] nib_d;

  assign ofs      = bus_addr[OFS_W-1:0];
  assign wr_cyc   = !bus_cs_n && !bus_wr_n;
  assign in_blk   = bus_addr[ADDR_W-1:OFS_W] == BASE_ADDR[ADDR_W-1:OFS_W];
  assign hit_part = wr_cyc && in_blk && !ofs[OFS_W-1];
  assign hit_bc   = wr_cyc && in_blk && (ofs == BC_OFS);
  assign part     = ofs[0];
  assign sel      = ofs[CH_BITS:1];

  always_comb begin
    if (left_just) nib_pat = part ? 3'b001 : 3'b110;
    else           nib_pat = part ? 3'b100 : 3'b011;
    if (!hit_part)     data_d = '0;
    else if (left_just) data_d = part ? {8'h00, bus_data[7:4]} : {bus_data, 4'h0};
    else               data_d = part ? {bus_data[3:0], 8'h00} : {4'h0, bus_data};
  end

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    logic sel_k;
    assign sel_k = hit_part && (sel == CH_BITS'(k));
    assign wr_d[k] = sel_k || hit_bc;
    assign ld_d[k] = (sel_k && part && !bcast_mode) || hit_bc;
    assign nib_d[3*k +: 3] = sel_k ? nib_pat : 3'b000;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ch_wr_n   <= '1;
      ch_nib_n  <= '1;
      ch_ldac_n <= '1;
      ch_data   <= '0;
    end else begin
      ch_wr_n   <= ~wr_d;
      ch_nib_n  <= ~nib_d;
      ch_ldac_n <= ~ld_d;
      ch_data   <= data_d;
    end
  end
endmodule

module dac_bus_loader_chk #(
  parameter int ADDR_W = 16,
  parameter int CH_BITS = 2,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h04C0
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [ADDR_W-1:0]         bus_addr,
  input logic                      bus_cs_n,
  input logic                      bus_wr_n,
  input logic                      bcast_mode,
  input logic [(1<<CH_BITS)-1:0]   ch_wr_n,
  input logic [3*(1<<CH_BITS)-1:0] ch_nib_n,
  input logic [(1<<CH_BITS)-1:0]   ch_ldac_n,
  input logic [11:0]               ch_data
);
  localparam int NUM_CH = 1 << CH_BITS;
  localparam int OFS_W  = CH_BITS + 2;

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cs_n || bus_wr_n) |=> (&ch_wr_n && &ch_ldac_n && &ch_nib_n && ch_data == '0));

  // R9
  outside_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr[ADDR_W-1:OFS_W] != BASE_ADDR[ADDR_W-1:OFS_W]) |=>
      (&ch_wr_n && &ch_ldac_n && &ch_nib_n));

  // R10
  single_chan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(~ch_wr_n) <= 1) || (ch_wr_n == '0));

  // R7
  bcast_ldac_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(bcast_mode) && !(&ch_ldac_n)) |-> (ch_ldac_n == '0));

  // R8
  bcast_no_nib_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_wr_n == '0) |-> (&ch_nib_n && ch_ldac_n == '0));

  for (genvar k = 0; k < NUM_CH; k++) begin : g_k
    // R10
    nib_needs_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(&ch_nib_n[3*k +: 3]) |-> !ch_wr_n[k]);
    // R6
    ldac_needs_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ch_ldac_n[k] |-> !ch_wr_n[k]);
  end
endmodule

bind dac_bus_loader dac_bus_loader_chk #(
  .ADDR_W(ADDR_W), .CH_BITS(CH_BITS), .BASE_ADDR(BASE_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_cs_n(bus_cs_n),
  .bus_wr_n(bus_wr_n), .bcast_mode(bcast_mode), .ch_wr_n(ch_wr_n),
  .ch_nib_n(ch_nib_n), .ch_ldac_n(ch_ldac_n), .ch_data(ch_data)
);

// File: tb/sim_dac_bus_loader.sv
module sim_dac_bus_loader;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] BASE = 16'h04C0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [7:0]  bus_data = '0;
  logic bus_cs_n = 1'b1, bus_wr_n = 1'b1, left_just = 1'b0, bcast_mode = 1'b0;
  logic [3:0]  ch_wr_n, ch_ldac_n;
  logic [11:0] ch_nib_n, ch_data;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dac_bus_loader #(.ADDR_W(16), .CH_BITS(2), .BASE_ADDR(BASE)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_data(bus_data),
    .bus_cs_n(bus_cs_n), .bus_wr_n(bus_wr_n), .left_just(left_just),
    .bcast_mode(bcast_mode), .ch_wr_n(ch_wr_n), .ch_nib_n(ch_nib_n),
    .ch_ldac_n(ch_ldac_n), .ch_data(ch_data)
  );

  localparam logic [31:0] QUIET = {4'hF, 12'hFFF, 4'hF, 12'h000};

  function automatic logic [31:0] model(logic [15:0] a, logic [7:0] d,
                                        logic cs_n, logic wr_n, logic lj, logic bm);
    logic [3:0] ew = 4'hF, el = 4'hF;
    logic [11:0] en = 12'hFFF, ed = 12'h000;
    int o = int'(a[3:0]);
    int ch = o / 2;
    int p = o % 2;
    if (!cs_n && !wr_n && a[15:4] == BASE[15:4]) begin
      if (o < 8) begin
        ew[ch] = 1'b0;
        if (!lj) begin
          if (p == 1) begin en[3*ch+2] = 1'b0; ed = {d[3:0], 8'h00}; end
          else begin en[3*ch+1] = 1'b0; en[3*ch] = 1'b0; ed = {4'h0, d}; end
        end else begin
          if (p == 1) begin en[3*ch] = 1'b0; ed = {8'h00, d[7:4]}; end
          else begin en[3*ch+2] = 1'b0; en[3*ch+1] = 1'b0; ed = {d, 4'h0}; end
        end
        if (p == 1 && !bm) el[ch] = 1'b0;
      end else if (o == 8) begin
        ew = 4'h0; el = 4'h0;
      end
    end
    return {ew, en, el, ed};
  endfunction

  task automatic compare(string req, logic [31:0] exp);
    logic [31:0] got = {ch_wr_n, ch_nib_n, ch_ldac_n, ch_data};
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s addr=%h data=%h lj=%0b bm=%0b: got %h expected %h",
               req, bus_addr, bus_data, left_just, bcast_mode, got, exp);
    end
  endtask

  task automatic op(string req, logic [15:0] a, logic [7:0] d, logic cs_n, logic wr_n);
    logic [31:0] exp;
    bus_addr = a; bus_data = d; bus_cs_n = cs_n; bus_wr_n = wr_n;
    exp = model(a, d, cs_n, wr_n, left_just, bcast_mode);
    @(negedge clk);
    compare(req, exp);
    bus_cs_n = 1'b1; bus_wr_n = 1'b1; bus_data = ~d;
    @(negedge clk);
    compare({req, " R2 pulse end"}, QUIET);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    string tag;
    logic [7:0] pats[3];
    @(negedge clk);
    compare("R1 in reset", QUIET);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1 after release", QUIET);

    for (int lj = 0; lj < 2; lj++) begin
      for (int bm = 0; bm < 2; bm++) begin
        left_just = 1'(lj); bcast_mode = 1'(bm);
        for (int o = 0; o < 16; o++) begin
          pats[0] = 8'hA5; pats[1] = 8'h3C; pats[2] = {4'(o), ~4'(o)};
          for (int i = 0; i < 3; i++) begin
            if (o < 8) begin
              tag = lj ? "R3 R5 R10" : "R3 R4 R10";
              if (o % 2 == 1) tag = {tag, bm ? " R7" : " R6"};
            end else if (o == 8) tag = "R8";
            else tag = "R9 unused offset";
            op(tag, BASE | 16'(o), pats[i], 1'b0, 1'b0);
          end
        end
        op("R9 below block", BASE - 16'd1, 8'h5A, 1'b0, 1'b0);
        op("R9 above block", BASE + 16'd16, 8'h5A, 1'b0, 1'b0);
        op("R9 far address", BASE ^ 16'h8000, 8'h11, 1'b0, 1'b0);
        op("R2 cs high", BASE | 16'd1, 8'hFF, 1'b1, 1'b0);
        op("R2 wr high", BASE | 16'd8, 8'hFF, 1'b0, 1'b1);
      end
    end

    left_just = 1'b0; bcast_mode = 1'b1;
    for (int c = 0; c < 4; c++) begin
      op("R4 R7 load low", BASE | 16'(2*c), 8'(8'h10 + c), 1'b0, 1'b0);
      op("R4 R7 load high", BASE | 16'(2*c+1), 8'(c), 1'b0, 1'b0);
    end
    op("R8 broadcast update", BASE | 16'd8, 8'h00, 1'b0, 1'b0);

    bus_addr = BASE | 16'd3; bus_data = 8'h0F; bus_cs_n = 1'b0; bus_wr_n = 1'b0;
    bcast_mode = 1'b0;
    @(negedge clk);
    compare("R2 back-to-back first R6", model(BASE | 16'd3, 8'h0F, 1'b0, 1'b0, 1'b0, 1'b0));
    bus_addr = BASE | 16'd4; bus_data = 8'hC3;
    @(negedge clk);
    compare("R2 back-to-back second R10", model(BASE | 16'd4, 8'hC3, 1'b0, 1'b0, 1'b0, 1'b0));
    bus_cs_n = 1'b1; bus_wr_n = 1'b1;
    @(negedge clk);
    compare("R2 back-to-back end", QUIET);

    rst_n = 1'b0;
    #1;
    compare("R1 async reset", QUIET);
    @(negedge clk);
    rst_n = 1'b1;

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule